// File: doc/BRIEF.md
# Quadrature Interpolating Phase-Accumulator Synthesizer

This block produces a pair of signed samples, sine and cosine, of a programmable frequency. It is intended as the local carrier source for a colour-subcarrier demodulator running from a 50 MHz clock. A 32-bit phase register advances by a frequency word on each enabled clock. A separate phase-offset word is added to the register's value before each lookup and is never accumulated.

The waveform store holds one full cycle in 256 entries of 12 bits. The top 8 bits of the sample phase select an entry. The next 8 bits interpolate linearly toward the following entry, so the phase resolution is finer than the store size alone would give. Cosine is read from the same store at the sample phase plus a quarter turn. The store contents are computed when the design elaborates.

A consumer drives a frequency word, for example round(f / 50 MHz * 2^32) for a 3.58 MHz or 4.43 MHz subcarrier, together with an offset word and an enable. It then collects the samples on each cycle where the valid strobe is high.

Top module: `dds_quad_synth`

## Requirements
- R1: Reset sets the phase register to 0. Each clock edge with `en_i` high adds `tune_i` to it, modulo 2^32.
- R2: The sample phase is the phase register value before that edge's update plus `offset_i` sampled at the same edge, modulo 2^32. The offset is not accumulated.
- R3: Store entry k (k = 0..255) equals round(2047 * sin(2*pi*k/256)), with halves rounded away from zero. The entry index is sample phase bits [31:24], the fraction is bits [23:16], and bits [15:0] do not affect the output.
- R4: The output equals e[k] + floor((e[k+1] - e[k]) * frac / 256), and it always lies between e[k] and e[k+1].
- R5: For k = 255 the upper neighbour is entry 0.
- R6: The cosine output equals the value that R3 and R4 give at the sample phase plus 0x40000000.
- R7: When `en_i` is high at edge n, `valid_o` is high after edge n+1 and the matching samples are on `sin_o` and `cos_o` at the same time.
- R8: When `en_i` is low at an edge, the phase register is unchanged, `valid_o` is low one edge later, and `sin_o` and `cos_o` keep their last values.
- R9: While `rst` is high, `valid_o`, `sin_o` and `cos_o` are all 0 after the clock edge.
- R10: Frequency words of 2^31 and above wrap modulo 2^32, so the phase steps backward. Subcarrier-rate words produce the R3–R6 values on every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance the phase and emit a sample |
| tune_i | input | 32 | Phase increment per enabled clock |
| offset_i | input | 32 | Phase offset added before lookup |
| sin_o | output | 12 | Signed sine sample, two's complement |
| cos_o | output | 12 | Signed cosine sample, two's complement |
| valid_o | output | 1 | High when the samples are new |

## Verification
An error in the phase register shows up in the very next sample, and it never heals, because every later phase carries it. A wrong store entry or a wrong neighbour wrap affects only the samples whose index lands on or next to that entry, so the frequency-word sweep is set so that every index/fraction pair is visited. Any of these errors then reaches `sin_o` or `cos_o` two edges after the sample is requested. A pipeline fault, such as a dropped strobe or an output that moves while idle, shows on the first enable gap.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam real PI_R = 3.141592653589793;

  // Rounded full-cycle sine value; halves round away from zero
  function automatic int sine_entry(input int idx, input int depth, input int amp);
    real x;
    x = real'(amp) * $sin(2.0 * PI_R * real'(idx) / real'(depth));
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(0.5 - x);
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [PHASE_W-1:0] tune,
  output logic [PHASE_W-1:0] acc_o
);
  always_ff @(posedge clk) begin
    if (rst)     acc_o <= '0;
    else if (en) acc_o <= acc_o + tune;
  end

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    en |=> (acc_o == $past(acc_o) + $past(tune)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_o));
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [AMP_W-1:0] data
);
  import dds_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PEAK  = (1 << (AMP_W - 1)) - 1;

  logic signed [AMP_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = AMP_W'(sine_entry(i, DEPTH, PEAK));
  end

  always_ff @(posedge clk) begin
    if (rst)     data <= '0;
    else if (ce) data <= mem[addr];
  end
endmodule

// File: rtl/dds_interp_lane.sv
module dds_interp_lane #(
  parameter int ADDR_W = 8,
  parameter int FRAC_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ce,
  input  logic                       out_en,
  input  logic [ADDR_W+FRAC_W-1:0]   phase_i,
  output logic signed [AMP_W-1:0]    y_o
);
  localparam int HI_W   = ADDR_W + FRAC_W;
  localparam int WIDE_W = AMP_W + FRAC_W + 2;

  logic [ADDR_W-1:0] idx_lo, idx_hi;
  logic signed [AMP_W-1:0] a_q, b_q;
  logic [FRAC_W-1:0] frac_q;

  assign idx_lo = phase_i[HI_W-1 -: ADDR_W];
  assign idx_hi = idx_lo + ADDR_W'(1);   // wraps last entry to entry 0

  // Stage 1: registered reads of both neighbours
  dds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom_lo (
    .clk(clk), .rst(rst), .ce(ce), .addr(idx_lo), .data(a_q));
  dds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom_hi (
    .clk(clk), .rst(rst), .ce(ce), .addr(idx_hi), .data(b_q));

  always_ff @(posedge clk) begin
    if (rst)     frac_q <= '0;
    else if (ce) frac_q <= phase_i[FRAC_W-1:0];
  end

  // Stage 2: linear interpolation
  logic signed [AMP_W:0]    diff;
  logic signed [WIDE_W-1:0] prod;
  logic signed [WIDE_W-1:0] a_ext, b_ext, wide_sum;

  assign diff     = {b_q[AMP_W-1], b_q} - {a_q[AMP_W-1], a_q};
  assign prod     = diff * $signed({1'b0, frac_q});
  assign a_ext    = {{(WIDE_W-AMP_W){a_q[AMP_W-1]}}, a_q};
  assign b_ext    = {{(WIDE_W-AMP_W){b_q[AMP_W-1]}}, b_q};
  assign wide_sum = a_ext + (prod >>> FRAC_W);

  always_ff @(posedge clk) begin
    if (rst)         y_o <= '0;
    else if (out_en) y_o <= wide_sum[AMP_W-1:0];
  end

  p_interp_span_r4: assert property (@(posedge clk) disable iff (rst)
    out_en |-> (wide_sum >= ((a_ext <= b_ext) ? a_ext : b_ext)) &&
               (wide_sum <= ((a_ext <= b_ext) ? b_ext : a_ext)));
endmodule

// File: rtl/dds_quad_synth.sv
module dds_quad_synth #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 8,
  parameter int FRAC_W  = 8,
  parameter int AMP_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] tune_i,
  input  logic [PHASE_W-1:0] offset_i,
  output logic [AMP_W-1:0]   sin_o,
  output logic [AMP_W-1:0]   cos_o,
  output logic               valid_o
);
  localparam int HI_W  = ADDR_W + FRAC_W;
  localparam int LO_W  = PHASE_W - HI_W;
  localparam int LANES = 2;

  logic [PHASE_W-1:0] acc;
  logic               carry;
  logic [HI_W-1:0]    phase_hi;
  logic               s1_valid;
  logic signed [AMP_W-1:0] lane_y [LANES];

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .en(en_i), .tune(tune_i), .acc_o(acc));

  // Only the upper bits reach the table; the lower half contributes its carry
  assign carry    = ({1'b0, acc[LO_W-1:0]} + {1'b0, offset_i[LO_W-1:0]}) >
                    {1'b0, {LO_W{1'b1}}};
  assign phase_hi = acc[PHASE_W-1:LO_W] + offset_i[PHASE_W-1:LO_W] +
                    {{(HI_W-1){1'b0}}, carry};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [HI_W-1:0] TURN = HI_W'(g) << (HI_W - 2);
    dds_interp_lane #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .AMP_W(AMP_W)) u_lane (
      .clk(clk), .rst(rst), .ce(en_i), .out_en(s1_valid),
      .phase_i(phase_hi + TURN), .y_o(lane_y[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      s1_valid <= en_i;
      valid_o  <= s1_valid;
    end
  end

  assign sin_o = lane_y[0];
  assign cos_o = lane_y[1];

  p_req_to_stage_r7: assert property (@(posedge clk) disable iff (rst)
    en_i |=> s1_valid);
  p_stage_to_out_r7: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> valid_o);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> (!valid_o && $stable(sin_o) && $stable(cos_o)));
endmodule

// File: tb/sim_dds_quad_synth.sv
module sim_dds_quad_synth;
  localparam int CLK_PERIOD = 20;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0;
  logic [31:0] tune_i = '0, offset_i = '0;
  logic [11:0] sin_o, cos_o;
  logic valid_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // bench model state
  logic [31:0] m_acc;
  bit m_s1v, m_ov;
  int m_s1s, m_s1c, m_os, m_oc;

  dds_quad_synth u0 (.clk(clk), .rst(rst), .en_i(en_i), .tune_i(tune_i),
    .offset_i(offset_i), .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int tbl(input int k);
    real x;
    x = 2047.0 * $sin(2.0 * 3.141592653589793 * real'(k) / 256.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction

  function automatic int interp(input logic [31:0] ph);
    int k, f, a, b;
    k = int'(ph[31:24]); f = int'(ph[23:16]);
    a = tbl(k); b = tbl((k + 1) % 256);
    return a + (((b - a) * f) >>> 8);
  endfunction

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_acc = '0; m_s1v = 0; m_ov = 0; m_s1s = 0; m_s1c = 0; m_os = 0; m_oc = 0;
  endtask

  task automatic tick(input string req, input bit e, input logic [31:0] t, input logic [31:0] o);
    logic [31:0] ph;
    en_i = e; tune_i = t; offset_i = o;
    @(posedge clk);
    if (rst) model_reset();
    else begin
      m_ov = m_s1v;
      if (m_s1v) begin m_os = m_s1s; m_oc = m_s1c; end
      m_s1v = e;
      if (e) begin
        ph = m_acc + o;
        m_s1s = interp(ph);
        m_s1c = interp(ph + 32'h4000_0000);
        m_acc = m_acc + t;
      end
    end
    @(negedge clk);
    cmp(req, "valid", int'(valid_o), int'(m_ov));
    cmp(req, "sin", int'($signed(sin_o)), m_os);
    cmp(req, "cos", int'($signed(cos_o)), m_oc);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int s_a, c_a;
    logic [31:0] ntsc, pal;
    model_reset();
    ntsc = 32'($rtoi(3579545.0 / 50.0e6 * 4294967296.0 + 0.5));
    pal  = 32'($rtoi(4433619.0 / 50.0e6 * 4294967296.0 + 0.5));
    rst = 1'b1;
    repeat (3) tick("R9", 1'b1, 32'h0100_0000, 32'h1234_0000);
    rst = 1'b0;
    tick("R9", 1'b0, 0, 0);

    // R3/R4/R5: every index/fraction pair visited
    for (int i = 0; i < 65536 + 4; i++) tick("R3", 1'b1, 32'h0001_0000, 32'h0000_0000);
    // R1: coarse steps from a fresh start
    rst = 1'b1; tick("R9", 1'b0, 0, 0); rst = 1'b0;
    for (int i = 0; i < 600; i++) tick("R1", 1'b1, 32'h0080_0000 + 32'(i & 7), 32'h0);
    // R2: offset changes every sample
    for (int i = 0; i < 600; i++) tick("R2", 1'b1, 32'h0123_4567, 32'(i) * 32'h9E37_79B9);
    // R10: subcarrier words and a backward step
    for (int i = 0; i < 1500; i++) tick("R10", 1'b1, ntsc, 32'h0);
    for (int i = 0; i < 1500; i++) tick("R10", 1'b1, pal, 32'h1000_0000);
    for (int i = 0; i < 400; i++) tick("R10", 1'b1, 32'hF0F0_F0F1, 32'h0);
    // R8: enable gaps
    for (int i = 0; i < 600; i++) tick("R8", (i % 3) != 0, 32'h0345_6789, 32'h0);
    for (int i = 0; i < 5; i++) tick("R8", 1'b0, 32'h7777_7777, 32'h5555_5555);
    // R7: single enable pulse
    tick("R7", 1'b1, 32'h0, 32'h2000_0000);
    cmp("R7", "valid after 1 edge", int'(valid_o), 0);
    tick("R7", 1'b0, 32'h0, 32'h0);
    cmp("R7", "valid after 2 edges", int'(valid_o), 1);
    tick("R7", 1'b0, 32'h0, 32'h0);
    cmp("R7", "valid after 3 edges", int'(valid_o), 0);

    // R5: last entry interpolates toward entry 0 (phase register held, offset steers)
    rst = 1'b1; tick("R9", 1'b0, 0, 0); rst = 1'b0;
    tick("R5", 1'b1, 32'h0, 32'hFFFF_0000);
    tick("R5", 1'b0, 32'h0, 32'h0);
    cmp("R5", "sin at idx 255 frac 255", int'($signed(sin_o)), tbl(255) + (((tbl(0) - tbl(255)) * 255) >>> 8));

    // R6: cosine at phase p equals sine at p + quarter turn
    tick("R6", 1'b1, 32'h0, 32'h1357_9BDF);
    tick("R6", 1'b1, 32'h0, 32'h1357_9BDF + 32'h4000_0000);
    c_a = int'($signed(cos_o));
    tick("R6", 1'b0, 32'h0, 32'h0);
    s_a = int'($signed(sin_o));
    cmp("R6", "cos vs shifted sin", c_a, s_a);
    // R3: low 16 phase bits have no effect
    tick("R3", 1'b1, 32'h0, 32'h2A40_0000);
    tick("R3", 1'b1, 32'h0, 32'h2A40_FFFF);
    s_a = int'($signed(sin_o));
    tick("R3", 1'b0, 32'h0, 32'h0);
    cmp("R3", "low bits ignored", int'($signed(sin_o)), s_a);

    rst = 1'b1; tick("R9", 1'b1, 32'h1, 32'h1); rst = 1'b0;
    cmp("R9", "valid in reset", int'(valid_o), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule